// File: doc/BRIEF.md
# Radio Transceiver Command Register Bank

This block is the control-port end of a sub-GHz FSK radio transceiver. A host writes 16-bit command words over a four-wire SPI link (mode 0, active-low select, most significant bit first). The block samples the link with its own system clock, frames each command, works out the command type from the leading byte, and updates a small bank of configuration registers. Each register starts at a fixed power-on value. The decoded register contents leave the block as parallel fields. A one-cycle strobe for each command type, together with the full command word, lets neighbouring logic act on commands whose settings this bank does not keep.

Some commands return data while they are being written. The first byte shifted out on MISO always carries the upper half of a status word. The second byte carries the rest of the status word during a status read, a received data byte during a FIFO read, and zeros for every other command. Two rules decide the register contents. First, the receiver and transmitter enable bits of the power register pull their dependent enables on. Second, a software-reset command returns every register to its power-on value.

Top module: `xcvr_cmd_bank`

## Requirements
- R1: After reset the register outputs hold: config 0x08, power 0x08, frequency 0x680, data rate 0x23, FIFO/reset 0x80, AFC 0xF7, transmitter control 0x00, PLL 0x77. All strobes are low and MISO is low.
- R2: A command takes effect only when chip select rises after exactly 16 SCK rising edges. Frames of 15 or 17 edges change no register and raise no strobe. Bits are shifted in MSB first.
- R3: A leading byte whose upper nibble is 0xA sets the 12-bit frequency register. Its bits 11..8 come from the leading byte's low nibble and bits 7..0 from the second byte.
- R4: A write with leading byte 0x82 stores the second byte in the power register, bits 7..0 = receiver, baseband, transmitter, synthesizer, crystal, low-battery detector, wake-up timer, clock-output disable. If bit 7 is set, bits 6, 4 and 3 are also stored set. If bit 5 is set, bits 4 and 3 are also stored set.
- R5: The second byte is stored unchanged by these leading bytes: 0x80 config, 0xC6 data rate, 0xCA FIFO/reset, 0xC4 AFC, 0xCC PLL. It is also stored unchanged when the top seven bits of the leading byte are 1001100, which selects transmitter control.
- R6: A leading byte whose top five bits are 10010 is receiver control. A leading byte whose top three bits are 111 is the wake-up timer, except that 0xFE is always software reset.
- R7: A software-reset command (0xFE) restores every register to its R1 value.
- R8: A leading byte that matches no command type raises no strobe and changes no register.
- R9: A committed command raises exactly one bit of cmd_strobe for one cycle. In the same cycle the register update is visible and cmd_word holds the frame. Bit index by type: 0 config, 1 power, 2 frequency, 3 data rate, 4 receiver control, 5 data filter (0xC2), 6 FIFO/reset, 7 sync pattern (0xCE), 8 FIFO read (0xB0), 9 AFC, 10 transmitter control, 11 PLL, 12 transmit byte (0xB8), 13 software reset, 14 wake-up timer, 15 low duty cycle (0xC8), 16 low battery/clock (0xC0), 17 status read (0x00).
- R10: The status word is captured when chip select falls. Its bit 15 is irq_flags[9], bit 14 is the internal power-on flag, bits 13..5 are irq_flags[8:0], and bits 4..0 are afc_offset. The power-on flag is set by reset and cleared when a status read (0x00) is committed.
- R11: MISO shifts the status word's upper byte during the first eight bits of every frame. During the last eight bits it carries the status lower byte for 0x00, rx_data for 0xB0, and zeros for any other opcode. MISO is low while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from host |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| irq_flags | input | 10 | Live interrupt/state flags for the status word |
| afc_offset | input | 5 | Live AFC offset for the status word |
| rx_data | input | 8 | Received byte returned by a FIFO read |
| cfg_reg | output | 8 | Configuration register |
| pwr_reg | output | 8 | Power register after enable implication |
| freq_reg | output | 12 | Frequency register |
| rate_reg | output | 8 | Data-rate register |
| fifo_reg | output | 8 | FIFO/reset mode register |
| afc_reg | output | 8 | AFC register |
| txc_reg | output | 8 | Transmitter control register |
| pll_reg | output | 8 | PLL register |
| cmd_strobe | output | 18 | One-cycle strobe per command type |
| cmd_word | output | 16 | Last committed command word |

## Verification
The bench builds the block with the default of two synchronizer stages. It drives SCK with a half period of six system clocks, which leaves several cycles of margin after the synchronizer and counter delay before each MISO bit is sampled. This exposes the edge that lies between the two bytes of every frame. At that point the opcode has just been captured and the block must switch the second-byte source to status, received data or zero. The bench also runs frames one edge short and one edge long, overlapping prefixes, and the wake-up prefix colliding with software reset.

// File: rtl/xcvr_pkg.sv
// Shared constants, command-type encoding and the power-enable rule
// for the transceiver command bank. Assumes 16-bit frames, 8-bit opcode.
package xcvr_pkg;

    localparam int FRAME_BITS = 16;
    localparam int OP_BITS    = 8;
    localparam int N_CMD      = 18;

    // Command types; the value is the strobe bit index.
    typedef enum logic [4:0] {
        C_CFG   = 5'd0,  C_PWR   = 5'd1,  C_FREQ  = 5'd2,  C_RATE  = 5'd3,
        C_RXCTL = 5'd4,  C_FILT  = 5'd5,  C_FIFO  = 5'd6,  C_SYNC  = 5'd7,
        C_FRD   = 5'd8,  C_AFC   = 5'd9,  C_TXCTL = 5'd10, C_PLL   = 5'd11,
        C_TXB   = 5'd12, C_SRST  = 5'd13, C_WAKE  = 5'd14, C_DUTY  = 5'd15,
        C_LBAT  = 5'd16, C_STAT  = 5'd17, C_NONE  = 5'd31
    } cmd_e;

    localparam logic [OP_BITS-1:0] OP_FIFO_RD = 8'hB0;
    localparam logic [OP_BITS-1:0] OP_STATUS  = 8'h00;

    localparam logic [7:0]  INIT_CFG  = 8'h08;
    localparam logic [7:0]  INIT_PWR  = 8'h08;
    localparam logic [11:0] INIT_FREQ = 12'h680;
    localparam logic [7:0]  INIT_RATE = 8'h23;
    localparam logic [7:0]  INIT_FIFO = 8'h80;
    localparam logic [7:0]  INIT_AFC  = 8'hF7;
    localparam logic [7:0]  INIT_TXC  = 8'h00;
    localparam logic [7:0]  INIT_PLL  = 8'h77;

    // Receiver enable pulls baseband, synth, crystal; transmitter pulls synth, crystal.
    function automatic logic [7:0] pwr_imply(input logic [7:0] b);
        logic [7:0] r;
        r = b;
        if (b[7]) r = r | 8'h58;
        if (b[5]) r = r | 8'h18;
        return r;
    endfunction

endpackage

// File: rtl/xcvr_spi_frame.sv
// SPI mode-0 slave framer, oversampled by clk. Assumes clk is at least
// several times faster than SCK. Emits frame_valid for one cycle when
// chip select rises after exactly FRAME_BITS edges; shifts readback on MISO.
module xcvr_spi_frame
    import xcvr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sck,
    input  logic                  spi_csn,
    input  logic                  spi_mosi,
    input  logic [FRAME_BITS-1:0] status_word,
    input  logic [OP_BITS-1:0]    rx_byte,
    output logic                  spi_miso,
    output logic                  cs_act,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame_word
);
    localparam int CW = $clog2(FRAME_BITS + 2);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
    localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_BITS + 1);
    localparam logic [CW-1:0] CNT_OP   = CW'(OP_BITS - 1);
    localparam logic [2:0]    PIN_IDLE = 3'b010;   // {sck, csn, mosi}

    logic [SYNC_STAGES-1:0][2:0] sq;
    logic [2:0] s_now, s_prev;
    logic sck_rise, cs_fall, cs_rise;
    logic [CW-1:0] cnt;
    logic [FRAME_BITS-1:0] shreg, snap, tx;
    logic [OP_BITS-1:0] op_q;
    logic [IW-1:0] bidx;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage pin capture.
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= PIN_IDLE;
                else        sq <= {spi_sck, spi_csn, spi_mosi};
            end
        end else begin : g_chain
            // Multi-stage synchronizer chain for the three pins.
            always_ff @(posedge clk) begin
                if (!rst_n) sq <= {SYNC_STAGES{PIN_IDLE}};
                else        sq <= {sq[SYNC_STAGES-2:0], {spi_sck, spi_csn, spi_mosi}};
            end
        end
    endgenerate

    assign s_now = sq[SYNC_STAGES-1];

    // Previous synchronized pin values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev <= PIN_IDLE;
        else        s_prev <= s_now;
    end

    assign cs_act   = !s_now[1];
    assign sck_rise = cs_act && s_now[2] && !s_prev[2];
    assign cs_fall  = !s_now[1] && s_prev[1];
    assign cs_rise  = s_now[1] && !s_prev[1];

    // Bit counter, input shifter, opcode capture and status snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            op_q  <= '0;
            snap  <= '0;
        end else if (cs_fall) begin
            cnt  <= '0;
            snap <= status_word;
        end else if (sck_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], s_now[0]};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt == CNT_OP)  op_q <= {shreg[OP_BITS-2:0], s_now[0]};
        end
    end

    // Commit pulse only for an exact-length frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            frame_valid <= cs_rise && (cnt == CNT_FULL);
            if (cs_rise) frame_word <= shreg;
        end
    end

    // Readback source: high byte always status, low byte by opcode.
    always_comb begin
        tx = snap;
        if (op_q == OP_FIFO_RD)     tx[OP_BITS-1:0] = rx_byte;
        else if (op_q != OP_STATUS) tx[OP_BITS-1:0] = '0;
    end

    assign bidx     = IW'(FRAME_BITS - 1) - cnt[IW-1:0];
    assign spi_miso = cs_act && (cnt < CNT_FULL) && tx[bidx];

endmodule

// File: rtl/xcvr_cmd_decode.sv
// Opcode classifier: exact byte matches take priority over prefix matches,
// so 0xFE is software reset even though it lies in the wake-up prefix.
module xcvr_cmd_decode
    import xcvr_pkg::*;
(
    input  logic [OP_BITS-1:0] opcode,
    output cmd_e               kind
);
    // Exact matches first, then variable-length prefixes.
    always_comb begin
        kind = C_NONE;
        case (opcode)
            8'h80: kind = C_CFG;
            8'h82: kind = C_PWR;
            8'hC6: kind = C_RATE;
            8'hC2: kind = C_FILT;
            8'hCA: kind = C_FIFO;
            8'hCE: kind = C_SYNC;
            8'hB0: kind = C_FRD;
            8'hC4: kind = C_AFC;
            8'hCC: kind = C_PLL;
            8'hB8: kind = C_TXB;
            8'hFE: kind = C_SRST;
            8'hC8: kind = C_DUTY;
            8'hC0: kind = C_LBAT;
            8'h00: kind = C_STAT;
            default: begin
                if (opcode[7:4] == 4'hA)             kind = C_FREQ;
                else if (opcode[7:3] == 5'b10010)    kind = C_RXCTL;
                else if (opcode[7:1] == 7'b1001100)  kind = C_TXCTL;
                else if (opcode[7:5] == 3'b111)      kind = C_WAKE;
            end
        endcase
    end

endmodule

// File: rtl/xcvr_reg_bank.sv
// Configuration registers with fixed power-on values. Updates on a
// committed command and raises the matching one-hot strobe in the same cycle.
module xcvr_reg_bank
    import xcvr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  cmd_e                  cmd_kind,
    input  logic [FRAME_BITS-1:0] cmd_in,
    output logic [7:0]            cfg_reg,
    output logic [7:0]            pwr_reg,
    output logic [11:0]           freq_reg,
    output logic [7:0]            rate_reg,
    output logic [7:0]            fifo_reg,
    output logic [7:0]            afc_reg,
    output logic [7:0]            txc_reg,
    output logic [7:0]            pll_reg,
    output logic [N_CMD-1:0]      cmd_strobe,
    output logic [FRAME_BITS-1:0] cmd_word
);
    logic [7:0] arg;
    assign arg = cmd_in[OP_BITS-1:0];

    // Register writes, software reset and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_reg <= INIT_CFG;  pwr_reg  <= INIT_PWR;  freq_reg <= INIT_FREQ;
            rate_reg <= INIT_RATE; fifo_reg <= INIT_FIFO; afc_reg <= INIT_AFC;
            txc_reg <= INIT_TXC;  pll_reg  <= INIT_PLL;
            cmd_strobe <= '0;
            cmd_word   <= '0;
        end else begin
            cmd_strobe <= '0;
            if (cmd_valid) begin
                cmd_word <= cmd_in;
                if (cmd_kind != C_NONE) cmd_strobe <= N_CMD'(1) << cmd_kind;
                case (cmd_kind)
                    C_CFG:   cfg_reg  <= arg;
                    C_PWR:   pwr_reg  <= pwr_imply(arg);
                    C_FREQ:  freq_reg <= {cmd_in[11:8], arg};
                    C_RATE:  rate_reg <= arg;
                    C_FIFO:  fifo_reg <= arg;
                    C_AFC:   afc_reg  <= arg;
                    C_TXCTL: txc_reg  <= arg;
                    C_PLL:   pll_reg  <= arg;
                    C_SRST: begin
                        cfg_reg <= INIT_CFG;  pwr_reg  <= INIT_PWR;  freq_reg <= INIT_FREQ;
                        rate_reg <= INIT_RATE; fifo_reg <= INIT_FIFO; afc_reg <= INIT_AFC;
                        txc_reg <= INIT_TXC;  pll_reg  <= INIT_PLL;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/xcvr_cmd_bank.sv
// Top: SPI command register bank of a sub-GHz FSK transceiver control port.
// Assumes clk oversamples SCK; keeps the power-on status flag until a
// status read has been committed.
module xcvr_cmd_bank
    import xcvr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_csn,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic [9:0]  irq_flags,
    input  logic [4:0]  afc_offset,
    input  logic [7:0]  rx_data,
    output logic [7:0]  cfg_reg,
    output logic [7:0]  pwr_reg,
    output logic [11:0] freq_reg,
    output logic [7:0]  rate_reg,
    output logic [7:0]  fifo_reg,
    output logic [7:0]  afc_reg,
    output logic [7:0]  txc_reg,
    output logic [7:0]  pll_reg,
    output logic [17:0] cmd_strobe,
    output logic [15:0] cmd_word
);
    logic                  cs_act;
    logic                  frame_valid;
    logic [FRAME_BITS-1:0] frame_word;
    logic [FRAME_BITS-1:0] status_word;
    cmd_e                  kind;
    logic                  por_flag;

    // Power-on flag: set by reset, cleared by a committed status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                             por_flag <= 1'b1;
        else if (frame_valid && kind == C_STAT) por_flag <= 1'b0;
    end

    assign status_word = {irq_flags[9], por_flag, irq_flags[8:0], afc_offset};

    xcvr_spi_frame #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
        .status_word(status_word), .rx_byte(rx_data),
        .spi_miso(spi_miso), .cs_act(cs_act),
        .frame_valid(frame_valid), .frame_word(frame_word)
    );

    xcvr_cmd_decode u_dec (
        .opcode(frame_word[FRAME_BITS-1:FRAME_BITS-OP_BITS]),
        .kind(kind)
    );

    xcvr_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(frame_valid), .cmd_kind(kind), .cmd_in(frame_word),
        .cfg_reg(cfg_reg), .pwr_reg(pwr_reg), .freq_reg(freq_reg),
        .rate_reg(rate_reg), .fifo_reg(fifo_reg), .afc_reg(afc_reg),
        .txc_reg(txc_reg), .pll_reg(pll_reg),
        .cmd_strobe(cmd_strobe), .cmd_word(cmd_word)
    );

endmodule

// File: rtl/xcvr_cmd_bank_chk.sv
// Property checker for xcvr_cmd_bank, attached with bind below.
module xcvr_cmd_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_act,
    input logic        spi_miso,
    input logic [17:0] cmd_strobe,
    input logic [7:0]  pwr_reg,
    input logic [11:0] freq_reg
);
    p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe));

    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != 18'd0) |=> (cmd_strobe == 18'd0));

    p_rx_implies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_reg[7] |-> (pwr_reg[6] && pwr_reg[4] && pwr_reg[3]));

    p_tx_implies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_reg[5] |-> (pwr_reg[4] && pwr_reg[3]));

    p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !spi_miso);

    p_freq_only_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_reg) |-> (cmd_strobe[2] || cmd_strobe[13]));

endmodule

bind xcvr_cmd_bank xcvr_cmd_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .spi_miso(spi_miso),
    .cmd_strobe(cmd_strobe), .pwr_reg(pwr_reg), .freq_reg(freq_reg)
);

// File: tb/tb_xcvr_cmd_bank.sv
module tb_xcvr_cmd_bank;
    localparam int CLK_P = 10;
    localparam int HP    = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic [9:0] fl = '0;
    logic [4:0] afc = '0;
    logic [7:0] rxd = '0;
    logic miso;
    logic [7:0] cfg, pwr, rate, fifo, afcr, txc, pll;
    logic [11:0] freq;
    logic [17:0] stb, seen;
    logic [15:0] cw, rd;
    logic clr_seen = 1'b0;
    logic por_exp = 1'b1;
    int checks = 0, errors = 0;
    bit done = 0;

    xcvr_cmd_bank dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .irq_flags(fl), .afc_offset(afc), .rx_data(rxd),
        .cfg_reg(cfg), .pwr_reg(pwr), .freq_reg(freq), .rate_reg(rate),
        .fifo_reg(fifo), .afc_reg(afcr), .txc_reg(txc), .pll_reg(pll),
        .cmd_strobe(stb), .cmd_word(cw)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (clr_seen) seen <= '0;
        else          seen <= seen | stb;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Send nb bits of w MSB first; capture MISO before each rising SCK.
    task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] r);
        r = '0;
        clr_seen = 1'b1; wclk(1); clr_seen = 1'b0;
        csn = 1'b0; wclk(HP);
        for (int i = 0; i < nb; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            wclk(HP);
            if (i < 16) r[15-i] = miso;
            sck = 1'b1; wclk(HP);
            sck = 1'b0;
        end
        wclk(HP);
        csn = 1'b1;
        if (nb == 16 && w[15:8] == 8'h00) por_exp = 1'b0;
        wclk(12);
    endtask

    function automatic logic [15:0] stat_model();
        return {fl[9], por_exp, fl[8:0], afc};
    endfunction

    task automatic t_reset();
        chk("R1 cfg", cfg, 8'h08);   chk("R1 pwr", pwr, 8'h08);
        chk("R1 freq", freq, 12'h680); chk("R1 rate", rate, 8'h23);
        chk("R1 fifo", fifo, 8'h80); chk("R1 afc", afcr, 8'hF7);
        chk("R1 txc", txc, 8'h00);   chk("R1 pll", pll, 8'h77);
        chk("R1 strobe", stb, 18'd0); chk("R1/R11 miso idle", miso, 1'b0);
    endtask

    task automatic t_freq();
        logic [15:0] r;
        xfer(16'hA123, 16, r);
        chk("R3 freq", freq, 12'h123);
        chk("R9 strobe freq", seen, 18'd1 << 2);
        chk("R9 cmd_word", cw, 16'hA123);
        xfer(16'hAFED, 16, r);
        chk("R3 freq max nibble", freq, 12'hFED);
    endtask

    task automatic t_power();
        logic [15:0] r;
        xfer(16'h8280, 16, r); chk("R4 rx implies", pwr, 8'hD8);
        xfer(16'h8220, 16, r); chk("R4 tx implies", pwr, 8'h38);
        xfer(16'h82A0, 16, r); chk("R4 both", pwr, 8'hF8);
        xfer(16'h8201, 16, r); chk("R4 plain", pwr, 8'h01);
        chk("R9 strobe pwr", seen, 18'd1 << 1);
    endtask

    task automatic t_exact();
        logic [15:0] r;
        xfer(16'h80E7, 16, r); chk("R5 cfg", cfg, 8'hE7);  chk("R9 cfg stb", seen, 18'd1 << 0);
        xfer(16'hC691, 16, r); chk("R5 rate", rate, 8'h91); chk("R9 rate stb", seen, 18'd1 << 3);
        xfer(16'hCA5A, 16, r); chk("R5 fifo", fifo, 8'h5A); chk("R9 fifo stb", seen, 18'd1 << 6);
        xfer(16'hC412, 16, r); chk("R5 afc", afcr, 8'h12);  chk("R9 afc stb", seen, 18'd1 << 9);
        xfer(16'hCC33, 16, r); chk("R5 pll", pll, 8'h33);   chk("R9 pll stb", seen, 18'd1 << 11);
        xfer(16'h9953, 16, r); chk("R5 txc 99", txc, 8'h53); chk("R9 txc stb", seen, 18'd1 << 10);
        xfer(16'h98A4, 16, r); chk("R5 txc 98", txc, 8'hA4);
        xfer(16'hC2AC, 16, r); chk("R9 filter stb", seen, 18'd1 << 5);
        xfer(16'hB855, 16, r); chk("R9 txbyte stb", seen, 18'd1 << 12);
        chk("R9 txbyte word", cw, 16'hB855);
    endtask

    task automatic t_prefix();
        logic [15:0] r;
        xfer(16'h9312, 16, r); chk("R6 rxctl 93", seen, 18'd1 << 4);
        xfer(16'h97FF, 16, r); chk("R6 rxctl 97", seen, 18'd1 << 4);
        xfer(16'hE512, 16, r); chk("R6 wake E5", seen, 18'd1 << 14);
        xfer(16'hFFAA, 16, r); chk("R6 wake FF", seen, 18'd1 << 14);
        xfer(16'hFE00, 16, r); chk("R6 FE is reset", seen, 18'd1 << 13);
    endtask

    task automatic t_srst();
        logic [15:0] r;
        xfer(16'hA321, 16, r); xfer(16'h80C1, 16, r);
        xfer(16'hFE00, 16, r);
        chk("R7 freq", freq, 12'h680); chk("R7 cfg", cfg, 8'h08);
        chk("R7 pwr", pwr, 8'h08);     chk("R7 rate", rate, 8'h23);
        chk("R7 fifo", fifo, 8'h80);   chk("R7 afc", afcr, 8'hF7);
        chk("R7 txc", txc, 8'h00);     chk("R7 pll", pll, 8'h77);
    endtask

    task automatic t_unknown();
        logic [15:0] r;
        xfer(16'hA555, 16, r); xfer(16'h8011, 16, r);
        xfer(16'h5555, 16, r); chk("R8 no strobe 55", seen, 18'd0);
        xfer(16'h81FF, 16, r); chk("R8 no strobe 81", seen, 18'd0);
        chk("R8 freq kept", freq, 12'h555); chk("R8 cfg kept", cfg, 8'h11);
    endtask

    task automatic t_frame();
        logic [15:0] r;
        xfer(16'hA0FF, 15, r); chk("R2 short no strobe", seen, 18'd0);
        chk("R2 short freq kept", freq, 12'h555);
        xfer(16'hA0FF, 17, r); chk("R2 long no strobe", seen, 18'd0);
        chk("R2 long freq kept", freq, 12'h555);
        xfer(16'hA0FF, 16, r); chk("R2 exact frame", freq, 12'h0FF);
    endtask

    task automatic t_status();
        logic [15:0] r, e;
        fl = 10'h2A5; afc = 5'h13;
        e = stat_model();
        xfer(16'h0000, 16, r);
        chk("R10 first status", r, e);
        chk("R10 first status por set", r[14], 1'b1);
        chk("R9 status stb", seen, 18'd1 << 17);
        fl = 10'h15A; afc = 5'h0C;
        e = stat_model();
        xfer(16'h0000, 16, r);
        chk("R10 second status", r, e);
        chk("R10 por cleared", r[14], 1'b0);
    endtask

    task automatic t_readback();
        logic [15:0] r, e;
        fl = 10'h3C3; afc = 5'h05; rxd = 8'hC3;
        e = stat_model();
        xfer(16'hB000, 16, r);
        chk("R11 fifo read", r, {e[15:8], 8'hC3});
        chk("R9 fifo read stb", seen, 18'd1 << 8);
        rxd = 8'h3C;
        xfer(16'h8008, 16, r);
        chk("R11 other cmd low byte zero", r, {e[15:8], 8'h00});
        chk("R11 miso idle", miso, 1'b0);
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        t_reset();
        t_freq();
        t_power();
        t_exact();
        t_prefix();
        t_srst();
        t_unknown();
        t_frame();
        t_status();
        t_readback();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule